// File: doc/BRIEF.md
# Configuration Transaction Controller

This block is a small command engine reached through three 32-bit registers: a data word, a control word and a status word. Software packs a command into the control word: the direction, a controller select, a function code, a site, a board position and a device index. When the start bit is set in that same write, the command runs at once. The command reads or writes one entry of an internal table. Oscillator frequencies are kept for a main site and a secondary site, and voltage-sensor values can be read for both sites.

A successful read puts its result into the data word. A write takes its operand from the data word. The status word then shows completion, together with an error flag when the command matched no implemented route. Two commands on the main site raise a one-cycle request to shut the system down or to reboot it. A build parameter can mark the block as absent. In that build every register offset answers with a bus error and reads as zero.

Registers are selected by a 2-bit word index. Index 0 is the data word, index 1 the control word, index 2 the status word, and index 3 is unmapped.

Top module: `cfgx_ctrl`

## Requirements
- R1: After reset the data, control and status words read 0. The six main-site oscillator entries hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000 for devices 0 to 5. The secondary-site oscillator entries hold the values given by the `SEC_OSC_INIT` parameter.
- R2: Word index 0 is data, 1 is control and 2 is status; these answer with `rsp_err`=0. Word index 3 answers with `rsp_err`=1, reads 0, and a write to it changes nothing. `rsp_rdata` is 0 whenever the request is not a read.
- R3: The control word has these fields: start at bit 31, write at bit 30 (1 = write, 0 = read), controller select at 29:26, function at 25:20, site at 17:16, position at 15:12 and device at 11:0. Bits 31, 19 and 18 always read back as 0. All other bits read back as written.
- R4: A control write with bit 31 set makes status bit 0 (done) equal 1. Status bit 1 (error) is set when the command fails and cleared when it succeeds. A control write with bit 31 clear leaves status and data unchanged.
- R5: A command fails unless the controller select is 0, the position is 0 and the site is 0 (main) or 1 (secondary).
- R6: Function 1 reads an oscillator entry into the data word, or writes the data word into the entry. The entry is picked by the site and the device index.
- R7: Function 2 reads a voltage. Main-site device 0 returns `MAIN_VOLT` (3300000 by default). Secondary-site device i returns entry i of `SEC_VOLT`. A write with function 2 fails.
- R8: A write to main-site device 0 succeeds with function 7, 8, 9 or 11. Function 8 raises `shutdown_pulse` and function 9 raises `reboot_pulse`. Functions 7 and 11 change no state. Every other combination of function, direction, site and device fails.
- R9: A device index at or beyond the size of the addressed table fails and touches no entry. A failed read leaves the data word unchanged.
- R10: A write to the status word stores only bits 1:0 of the written value.
- R11: `shutdown_pulse` and `reboot_pulse` are high for exactly the one cycle after the clock edge that accepts the command.
- R12: With `PRESENT`=0 every request answers with `rsp_err`=1 and `rsp_rdata`=0, and both pulse outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word index of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the same cycle as the request |
| rsp_err | output | 1 | Bus error for this request |
| shutdown_pulse | output | 1 | One-cycle shutdown request |
| reboot_pulse | output | 1 | One-cycle reboot request |

## Verification
The assertions check on every cycle that a started command always sets the done bit, and that a bad select, position or site always sets the error bit. They also check that the control word drops its start and reserved bits, that a status write keeps only two bits, and that a pulse appears only after a matching accepted write. Further, they check that the two pulses are never high together and that a table entry changes only when it is the one being written. The values returned by each route are shown only by the bench's scenarios: the reset frequencies, the parameter voltages, the limits on the device index, and data left unchanged after a failed read. The same holds for the no-effect functions and for the absent build, which the bench compares against its reference model.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   localparam int REG_W      = 32;
   localparam int REG_ADDR_W = 2;

   // control word field layout
   localparam int CW_START  = 31;
   localparam int CW_WRITE  = 30;
   localparam int SEL_LSB   = 26;
   localparam int SEL_W     = 4;
   localparam int FN_LSB    = 20;
   localparam int FN_W      = 6;
   localparam int RSV_LSB   = 18;
   localparam int SITE_LSB  = 16;
   localparam int SITE_W    = 2;
   localparam int POS_LSB   = 12;
   localparam int POS_W     = 4;
   localparam int DEV_W     = 12;

   localparam logic [REG_W-1:0] CTRL_KEEP =
      ~((REG_W'(1) << CW_START) | (REG_W'(3) << RSV_LSB));

   // register word indices
   localparam logic [REG_ADDR_W-1:0] IDX_DATA = 2'd0;
   localparam logic [REG_ADDR_W-1:0] IDX_CTRL = 2'd1;
   localparam logic [REG_ADDR_W-1:0] IDX_STAT = 2'd2;

   // function codes
   localparam logic [FN_W-1:0] FN_OSC      = 6'd1;
   localparam logic [FN_W-1:0] FN_VOLT     = 6'd2;
   localparam logic [FN_W-1:0] FN_VIDSEL   = 6'd7;
   localparam logic [FN_W-1:0] FN_SHUT     = 6'd8;
   localparam logic [FN_W-1:0] FN_REBOOT   = 6'd9;
   localparam logic [FN_W-1:0] FN_DISPMODE = 6'd11;

   typedef struct packed {
      logic             wr;
      logic [SEL_W-1:0] sel;
      logic [FN_W-1:0]  fn;
      logic [SITE_W-1:0] site;
      logic [POS_W-1:0] pos;
      logic [DEV_W-1:0] dev;
   } cfgx_cmd_t;

   typedef enum logic [2:0] {
      TGT_NONE, TGT_MAIN_OSC, TGT_SEC_OSC, TGT_MAIN_VOLT,
      TGT_SEC_VOLT, TGT_NOP, TGT_SHUT, TGT_REBOOT
   } cfgx_tgt_e;

   function automatic cfgx_cmd_t cmd_fields(input logic [REG_W-1:0] w);
      cfgx_cmd_t c;
      c.wr   = w[CW_WRITE];
      c.sel  = w[SEL_LSB +: SEL_W];
      c.fn   = w[FN_LSB +: FN_W];
      c.site = w[SITE_LSB +: SITE_W];
      c.pos  = w[POS_LSB +: POS_W];
      c.dev  = w[DEV_W-1:0];
      return c;
   endfunction

   function automatic int idx_w(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
   import cfgx_pkg::*;
#(
   parameter int N_MAIN_OSC  = 6,
   parameter int N_SEC_OSC   = 2,
   parameter int N_SEC_VSENS = 3
) (
   input  cfgx_cmd_t cmd,
   output logic      ok,
   output cfgx_tgt_e tgt
);
   localparam logic [DEV_W-1:0] MAIN_LIM  = DEV_W'(N_MAIN_OSC);
   localparam logic [DEV_W-1:0] SEC_LIM   = DEV_W'(N_SEC_OSC);
   localparam logic [DEV_W-1:0] VSENS_LIM = DEV_W'(N_SEC_VSENS);

   if (N_MAIN_OSC < 1 || N_MAIN_OSC > 4095) begin : g_bad_main
      $error("N_MAIN_OSC out of range");
   end
   if (N_SEC_OSC < 1 || N_SEC_OSC > 4095) begin : g_bad_sec
      $error("N_SEC_OSC out of range");
   end
   if (N_SEC_VSENS < 1 || N_SEC_VSENS > 4095) begin : g_bad_vs
      $error("N_SEC_VSENS out of range");
   end

   logic routed;
   logic main_site;
   logic main_dev0;

   assign routed    = (cmd.sel == '0) && (cmd.pos == '0) && !cmd.site[1];
   assign main_site = (cmd.site == 2'd0);
   assign main_dev0 = main_site && (cmd.dev == '0);

   always_comb begin
      tgt = TGT_NONE;
      if (routed) begin
         case (cmd.fn)
            FN_OSC: begin
               if (main_site && cmd.dev < MAIN_LIM)       tgt = TGT_MAIN_OSC;
               else if (!main_site && cmd.dev < SEC_LIM)  tgt = TGT_SEC_OSC;
            end
            FN_VOLT: begin
               if (!cmd.wr) begin
                  if (main_dev0)                              tgt = TGT_MAIN_VOLT;
                  else if (!main_site && cmd.dev < VSENS_LIM) tgt = TGT_SEC_VOLT;
               end
            end
            FN_VIDSEL, FN_DISPMODE: if (cmd.wr && main_dev0) tgt = TGT_NOP;
            FN_SHUT:                if (cmd.wr && main_dev0) tgt = TGT_SHUT;
            FN_REBOOT:              if (cmd.wr && main_dev0) tgt = TGT_REBOOT;
            default:                tgt = TGT_NONE;
         endcase
      end
   end

   assign ok = (tgt != TGT_NONE);
endmodule

// File: rtl/cfgx_osc_table.sv
module cfgx_osc_table
   import cfgx_pkg::*;
#(
   parameter int ENTRIES = 6,
   parameter int DW      = 32,
   parameter logic [ENTRIES*DW-1:0] INIT = '0,
   localparam int IW = idx_w(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] ent [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          ent[g] <= INIT[g*DW +: DW];
         else if (wr_en && idx == IW'(g))     ent[g] <= wr_data;
      end

      // R6/R9: an entry moves only when it is the addressed write target
      a_r9_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && idx == IW'(g)) |=> $stable(ent[g]));
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (idx == IW'(i)) rd_data = ent[i];
   end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
   import cfgx_pkg::*;
#(
   parameter bit PRESENT     = 1'b1,
   parameter int N_MAIN_OSC  = 6,
   parameter int N_SEC_OSC   = 2,
   parameter int N_SEC_VSENS = 3,
   parameter logic [N_SEC_OSC*REG_W-1:0]   SEC_OSC_INIT = {32'd33000000, 32'd25000000},
   parameter logic [N_SEC_VSENS*REG_W-1:0] SEC_VOLT     = {32'd1800000, 32'd1000000, 32'd900000},
   parameter logic [REG_W-1:0]             MAIN_VOLT    = 32'd3300000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [REG_ADDR_W-1:0] req_addr,
   input  logic [REG_W-1:0]      req_wdata,
   output logic [REG_W-1:0]      rsp_rdata,
   output logic                  rsp_err,
   output logic                  shutdown_pulse,
   output logic                  reboot_pulse
);
   localparam int MIW = idx_w(N_MAIN_OSC);
   localparam int SIW = idx_w(N_SEC_OSC);

   function automatic logic [N_MAIN_OSC*REG_W-1:0] main_init();
      logic [N_MAIN_OSC*REG_W-1:0] v;
      for (int i = 0; i < N_MAIN_OSC; i++) begin
         if (i == 0)      v[i*REG_W +: REG_W] = 32'd50000000;
         else if (i == 1) v[i*REG_W +: REG_W] = 32'd23750000;
         else             v[i*REG_W +: REG_W] = 32'd24000000;
      end
      return v;
   endfunction

   localparam logic [N_MAIN_OSC*REG_W-1:0] MAIN_INIT = main_init();

   if (PRESENT) begin : g_live
      logic [REG_W-1:0] data_q, ctrl_q;
      logic [1:0]       stat_q;
      logic             shut_q, reb_q;
      logic             acc_wr, wr_data_w, wr_ctrl_w, wr_stat_w, fire;
      cfgx_cmd_t        cmd;
      logic             ok;
      cfgx_tgt_e        tgt;
      logic [REG_W-1:0] main_rd, sec_rd, volt_rd, result;

      assign acc_wr    = req_valid && req_write;
      assign wr_data_w = acc_wr && req_addr == IDX_DATA;
      assign wr_ctrl_w = acc_wr && req_addr == IDX_CTRL;
      assign wr_stat_w = acc_wr && req_addr == IDX_STAT;
      assign fire      = wr_ctrl_w && req_wdata[CW_START];
      assign cmd       = cmd_fields(req_wdata);

      cfgx_decode #(
         .N_MAIN_OSC (N_MAIN_OSC),
         .N_SEC_OSC  (N_SEC_OSC),
         .N_SEC_VSENS(N_SEC_VSENS)
      ) u_dec (
         .cmd(cmd),
         .ok (ok),
         .tgt(tgt)
      );

      cfgx_osc_table #(.ENTRIES(N_MAIN_OSC), .DW(REG_W), .INIT(MAIN_INIT)) u_main (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (fire && cmd.wr && tgt == TGT_MAIN_OSC),
         .idx    (cmd.dev[MIW-1:0]),
         .wr_data(data_q),
         .rd_data(main_rd)
      );

      cfgx_osc_table #(.ENTRIES(N_SEC_OSC), .DW(REG_W), .INIT(SEC_OSC_INIT)) u_sec (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (fire && cmd.wr && tgt == TGT_SEC_OSC),
         .idx    (cmd.dev[SIW-1:0]),
         .wr_data(data_q),
         .rd_data(sec_rd)
      );

      always_comb begin
         volt_rd = '0;
         for (int i = 0; i < N_SEC_VSENS; i++)
            if (cmd.dev == DEV_W'(i)) volt_rd = SEC_VOLT[i*REG_W +: REG_W];
      end

      always_comb begin
         case (tgt)
            TGT_MAIN_OSC:  result = main_rd;
            TGT_SEC_OSC:   result = sec_rd;
            TGT_MAIN_VOLT: result = MAIN_VOLT;
            TGT_SEC_VOLT:  result = volt_rd;
            default:       result = '0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
            shut_q <= 1'b0;
            reb_q  <= 1'b0;
         end else begin
            if (wr_data_w)                  data_q <= req_wdata;
            else if (fire && !cmd.wr && ok) data_q <= result;
            if (wr_ctrl_w)                  ctrl_q <= req_wdata & CTRL_KEEP;
            if (wr_stat_w)                  stat_q <= req_wdata[1:0];
            else if (fire)                  stat_q <= {!ok, 1'b1};
            shut_q <= fire && tgt == TGT_SHUT;
            reb_q  <= fire && tgt == TGT_REBOOT;
         end
      end

      always_comb begin
         rsp_rdata = '0;
         if (req_valid && !req_write) begin
            case (req_addr)
               IDX_DATA: rsp_rdata = data_q;
               IDX_CTRL: rsp_rdata = ctrl_q;
               IDX_STAT: rsp_rdata = {{(REG_W-2){1'b0}}, stat_q};
               default:  rsp_rdata = '0;
            endcase
         end
      end

      assign rsp_err        = req_valid && req_addr == 2'd3;
      assign shutdown_pulse = shut_q;
      assign reboot_pulse   = reb_q;

      // R4: every started command reports done
      a_r4_start_done: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_write && req_addr == IDX_CTRL && req_wdata[31]) |=> stat_q[0]);

      // R5: bad select, position or site always reports error
      a_r5_bad_route: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_write && req_addr == IDX_CTRL && req_wdata[31] &&
          (req_wdata[29:26] != 4'd0 || req_wdata[15:12] != 4'd0 || req_wdata[17]))
         |=> stat_q[1]);

      // R3: start and reserved bits never stored, other fields kept
      a_r3_ctrl_fields: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_write && req_addr == IDX_CTRL) |=>
         (ctrl_q[31] == 1'b0 && ctrl_q[19:18] == 2'b00 &&
          ctrl_q[30:20] == $past(req_wdata[30:20]) &&
          ctrl_q[17:0] == $past(req_wdata[17:0])));

      // R10: status write keeps two bits
      a_r10_stat_two_bits: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_write && req_addr == IDX_STAT) |=>
         (rsp_rdata == '0 || req_addr != IDX_STAT || !req_valid || req_write ||
          rsp_rdata[REG_W-1:2] == '0));

      // R8: a shutdown pulse follows an accepted shutdown write
      a_r8_shut_cause: assert property (@(posedge clk) disable iff (!rst_n)
         shutdown_pulse |-> $past(req_valid && req_write && req_addr == IDX_CTRL &&
                                  req_wdata[31:30] == 2'b11 && req_wdata[25:20] == 6'd8));

      // R8: a reboot pulse follows an accepted reboot write
      a_r8_reboot_cause: assert property (@(posedge clk) disable iff (!rst_n)
         reboot_pulse |-> $past(req_valid && req_write && req_addr == IDX_CTRL &&
                                req_wdata[31:30] == 2'b11 && req_wdata[25:20] == 6'd9));

      // R11: the two requests never coincide
      a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({shutdown_pulse, reboot_pulse}));
   end else begin : g_absent
      assign rsp_rdata      = '0;
      assign rsp_err        = req_valid;
      assign shutdown_pulse = 1'b0;
      assign reboot_pulse   = 1'b0;
   end
endmodule

// File: tb/cfgx_ctrl_tb.sv
module cfgx_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 2;
   localparam int NV = 3;
   localparam logic [NS*32-1:0] SOSC  = {32'd33000000, 32'd25000000};
   localparam logic [NV*32-1:0] SVOLT = {32'd1800000, 32'd1000000, 32'd900000};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata, off_rdata;
   logic        rsp_err, off_err, shutdown_pulse, reboot_pulse, off_shut, off_reb;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgx_ctrl #(.PRESENT(1'b1), .N_SEC_OSC(NS), .N_SEC_VSENS(NV),
               .SEC_OSC_INIT(SOSC), .SEC_VOLT(SVOLT)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .shutdown_pulse(shutdown_pulse), .reboot_pulse(reboot_pulse));

   cfgx_ctrl #(.PRESENT(1'b0)) dut_off (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(off_rdata),
      .rsp_err(off_err), .shutdown_pulse(off_shut), .reboot_pulse(off_reb));

   int checks = 0, errors = 0;
   bit done = 0;

   // behavioural reference state
   logic [31:0] m_data = 0, m_ctrl = 0;
   logic [1:0]  m_stat = 0;
   int unsigned m_main[6] = '{50000000, 23750000, 24000000, 24000000, 24000000, 24000000};
   int unsigned m_sec[NS];
   int unsigned m_volt[NV];
   bit exp_shut = 0, exp_reb = 0;

   task automatic chk(input bit good, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", tag, what, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [31:0] w);
      bit wr = w[30], ok = 0;
      int sel = w[29:26], fn = w[25:20], site = w[17:16], pos = w[15:12], dev = w[11:0];
      logic [31:0] rv = 0;
      if (sel == 0 && pos == 0 && site < 2) begin
         if (wr) begin
            if (fn == 1 && site == 0 && dev < 6)  begin m_main[dev] = m_data; ok = 1; end
            if (fn == 1 && site == 1 && dev < NS) begin m_sec[dev] = m_data; ok = 1; end
            if ((fn == 7 || fn == 11 || fn == 8 || fn == 9) && site == 0 && dev == 0) ok = 1;
            if (ok && fn == 8) exp_shut = 1;
            if (ok && fn == 9) exp_reb = 1;
         end else begin
            if (fn == 1 && site == 0 && dev < 6)  begin rv = m_main[dev]; ok = 1; end
            if (fn == 1 && site == 1 && dev < NS) begin rv = m_sec[dev]; ok = 1; end
            if (fn == 2 && site == 0 && dev == 0) begin rv = 3300000; ok = 1; end
            if (fn == 2 && site == 1 && dev < NV) begin rv = m_volt[dev]; ok = 1; end
         end
      end
      m_stat = ok ? 2'b01 : 2'b11;
      if (!wr && ok) m_data = rv;
   endtask

   // one bus cycle, compared against the model
   task automatic step(input bit v, input bit w, input logic [1:0] a,
                       input logic [31:0] d, input string tag);
      logic [31:0] er;
      @(negedge clk);
      chk(shutdown_pulse == exp_shut, "R8/R11", "shutdown_pulse", 32'(shutdown_pulse), 32'(exp_shut));
      chk(reboot_pulse == exp_reb, "R8/R11", "reboot_pulse", 32'(reboot_pulse), 32'(exp_reb));
      exp_shut = 0; exp_reb = 0;
      req_valid = v; req_write = w; req_addr = a; req_wdata = d;
      #1;
      er = 0;
      if (v && !w)
         case (a)
            2'd0: er = m_data;
            2'd1: er = m_ctrl;
            2'd2: er = {30'd0, m_stat};
            default: er = 0;
         endcase
      chk(rsp_rdata == er, tag, "rdata", rsp_rdata, er);
      chk(rsp_err == (v && a == 2'd3), "R2", "rsp_err", 32'(rsp_err), 32'(v && a == 2'd3));
      chk(off_err == v && off_rdata == 0 && !off_shut && !off_reb, "R12", "absent build",
          {off_rdata[29:0], off_err, off_shut | off_reb}, {30'd0, v, 1'b0});
      if (v && w) begin
         case (a)
            2'd0: m_data = d;
            2'd1: begin
               m_ctrl = d & 32'h7FF3FFFF;
               if (d[31]) run_cmd(d);
            end
            2'd2: m_stat = d[1:0];
            default: ;
         endcase
      end
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      step(1, 0, a, 32'hDEADBEEF, tag);
   endtask
   task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
      step(1, 1, a, d, tag);
   endtask
   task automatic cmd(input bit w, input int sel, input int fn, input int site,
                      input int pos, input int dev, input string tag);
      wr(2'd1, {1'b1, w, 4'(sel), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)}, tag);
      rd(2'd2, tag);
      rd(2'd0, tag);
   endtask

   initial begin
      for (int i = 0; i < NS; i++) m_sec[i] = SOSC[i*32 +: 32];
      for (int i = 0; i < NV; i++) m_volt[i] = SVOLT[i*32 +: 32];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(0, "R1"); rd(1, "R1"); rd(2, "R1");
      for (int i = 0; i < 6; i++) cmd(0, 0, 1, 0, 0, i, "R1");
      for (int i = 0; i < NS; i++) cmd(0, 0, 1, 1, 0, i, "R1");
      // R6 oscillator writes and read-back
      wr(0, 32'd12345678, "R6"); cmd(1, 0, 1, 0, 0, 2, "R6"); cmd(0, 0, 1, 0, 0, 2, "R6");
      wr(0, 32'd777, "R6");      cmd(1, 0, 1, 1, 0, 1, "R6"); cmd(0, 0, 1, 1, 0, 1, "R6");
      // R9 out of range device
      wr(0, 32'hA5A5A5A5, "R9");
      cmd(0, 0, 1, 0, 0, 6, "R9"); cmd(1, 0, 1, 1, 0, NS, "R9"); cmd(0, 0, 2, 1, 0, NV, "R9");
      cmd(0, 0, 1, 1, 0, 0, "R9");
      // R7 voltages
      cmd(0, 0, 2, 0, 0, 0, "R7"); cmd(0, 0, 2, 0, 0, 1, "R7");
      for (int i = 0; i < NV; i++) cmd(0, 0, 2, 1, 0, i, "R7");
      cmd(1, 0, 2, 0, 0, 0, "R7");
      // R5 routing failures
      cmd(0, 1, 1, 0, 0, 0, "R5"); cmd(0, 0, 1, 0, 3, 0, "R5");
      cmd(0, 0, 1, 2, 0, 0, "R5"); cmd(0, 0, 1, 3, 0, 0, "R5");
      // R8 system requests and no-effect functions
      cmd(1, 0, 8, 0, 0, 0, "R8"); cmd(1, 0, 9, 0, 0, 0, "R8");
      cmd(1, 0, 7, 0, 0, 0, "R8"); cmd(1, 0, 11, 0, 0, 0, "R8");
      cmd(0, 0, 8, 0, 0, 0, "R8"); cmd(1, 0, 8, 0, 0, 1, "R8"); cmd(1, 0, 9, 1, 0, 0, "R8");
      cmd(1, 0, 5, 0, 0, 0, "R8");
      // R11 back-to-back requests
      wr(1, 32'hC0800000, "R11"); wr(1, 32'hC0900000, "R11"); step(0, 0, 0, 0, "R11");
      // R3 control bits, R4 no start
      wr(1, 32'hFFFFFFFF, "R3"); rd(1, "R3"); rd(2, "R4");
      wr(2, 32'h0, "R4"); wr(1, 32'h40100000, "R4"); rd(2, "R4"); rd(0, "R4"); rd(1, "R3");
      // R10 status write
      wr(2, 32'hFFFFFFFE, "R10"); rd(2, "R10"); wr(2, 32'h00000001, "R10"); rd(2, "R10");
      // R2 unmapped offset
      rd(3, "R2"); wr(3, 32'h12345678, "R2"); rd(0, "R2"); rd(1, "R2"); rd(2, "R2");
      step(0, 0, 1, 0, "R2");
      step(0, 0, 0, 0, "R2");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule